// File: doc/BRIEF.md
# Serial Flash Boot Fetch Master

After reset, this block reads a configuration image from an external serial flash and hands it to a loader as 32-bit words. It works as an SPI mode 0 master. It drives chip select, serial clock and MOSI, and it samples MISO.

The fetch runs in a fixed order:

1. It sends a read opcode.
2. It sends a 24-bit start address of zero.
3. It runs a programmable number of dummy clocks.
4. It streams data with no gaps. Each received byte is most significant bit first, and every four bytes form a word with the first byte in the low lane.

The streaming continues until the loader raises its done input. The block then finishes the byte in flight and parks the flash pins at fixed levels.

A strap input selects supply-control mode. In this mode the block drives a group of flash supply pins high and waits a programmed number of clock cycles before the first access.

A 31-bit control word holds four settings: the clock ratio, the opcode, the dummy count and the power-up delay. It can be rewritten at any time through a register write strobe.
- A new clock ratio takes effect at the next serial clock period boundary, so a faster flash clock can be applied partway through the image.
- A new opcode or dummy count is used only if it is written before the command starts.

Top module: `spi_boot_fetch`

## Requirements
- R1: While reset is low, chip select is high, the serial clock is low, MOSI is low and word_valid is low.
- R2: The serial clock period is (ratio + 2) input clock cycles. Each period begins with a low phase of ceil(period/2) cycles, followed by a high phase of floor(period/2) cycles. The clock stays low whenever chip select is high. After reset the ratio is 15, giving a 17-cycle period.
- R3: The control word fields are fixed:
  - bits [3:0]: clock ratio.
  - bits [11:4]: read opcode.
  - bits [14:12]: dummy clock count.
  - bits [30:15]: power-up delay in clock cycles.
  - The reset value is 0x01F4003F, which decodes to ratio 15, opcode 0x03, zero dummy clocks and a delay of 1000.
  - A write replaces the whole word.
- R4: The first 32 bits on MOSI, sampled at the rising serial clock edges, are the opcode followed by 24 zero address bits, most significant bit first. MOSI never changes while the serial clock is high.
- R5: Exactly the programmed number of dummy clocks (0 to 7) pass between the last address bit and the first data bit.
- R6: MISO is sampled on each rising serial clock edge of the data phase.
  - Each group of 8 samples forms a byte, first sample in bit 7.
  - Bytes 0 to 3 of each group of four fill word bits [7:0], [15:8], [23:16] and [31:24].
  - Each word is presented with a single-cycle word_valid pulse.
- R7: A ratio written during the download changes the serial clock only at a period boundary. Every period has either the old or the new low/high split, and all later periods use the new split.
- R8: With supply_mode high, all supply pins are high while chip select is low. Chip select falls exactly (delay + 1) clock edges after reset is released, with the delay read live from the control word.
- R9: With supply_mode low, the supply pins stay low, and chip select falls on the first clock edge after reset is released.
- R10: After load_done, the download stops at a byte boundary. This is no later than the end of the byte after the one in progress. Chip select then goes high, the serial clock low, MOSI low and the supply pins low. No further words are produced until the next reset.
- R11: The opcode and dummy count are taken from the control word on the edge where the command starts, so a write made before that edge is honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the source of the serial clock |
| rst_n | input | 1 | Active-low reset; releasing it starts a fetch |
| supply_mode | input | 1 | Strap selecting supply-control mode |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 31 | Control word write value |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock |
| flash_mosi | output | 1 | Serial data to the flash |
| flash_miso | input | 1 | Serial data from the flash |
| flash_pwr | output | 3 | Flash supply pins |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | 32 | Assembled word |
| load_done | input | 1 | Loader request to stop the download |

## Verification
- **Chip select fall.** This is due P+1 clock edges after the edge at which reset is released (one edge without supply control). The bench counts rising edges from the release and inspects chip select half a cycle after each one.
- **MOSI command bits.** Each bit is read at the first falling-clock sample that shows the serial clock high. MOSI is held until the next serial period, so this sample is safe.
- **Phase lengths.** These are counted in whole falling-edge samples between serial clock transitions.
- **Words.** A word is visible the cycle after the rising serial edge of its 32st data bit, and is compared whenever word_valid is sampled high.
- **Stop point.** The bench raises load_done half a cycle after seeing the third word. The stop must then land after 96 or 104 data bits, depending on whether the fall edge of bit 96 beats the latched request.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

   localparam int RATIO_W = 4;
   localparam int OPC_W   = 8;
   localparam int DUMMY_W = 3;
   localparam int PWRC_W  = 16;
   localparam int CTRL_W  = RATIO_W + OPC_W + DUMMY_W + PWRC_W;

   // Field order is fixed by the register layout: ratio in the low bits.
   typedef struct packed {
      logic [PWRC_W-1:0]  pwr_cycles;
      logic [DUMMY_W-1:0] dummy;
      logic [OPC_W-1:0]   opcode;
      logic [RATIO_W-1:0] ratio;
   } ctrl_t;

   localparam logic [CTRL_W-1:0] CTRL_RESET = 31'h01F4003F;

   typedef enum logic [2:0] {
      ST_PWR   = 3'd0,
      ST_CMD   = 3'd1,
      ST_DUMMY = 3'd2,
      ST_DATA  = 3'd3,
      ST_DONE  = 3'd4
   } fetch_st_t;

endpackage

// File: rtl/spi_boot_clkdiv.sv
module spi_boot_clkdiv #(
   parameter int RATIO_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [RATIO_W-1:0] ratio,
   output logic               sck,
   output logic               rise_evt,
   output logic               fall_evt
);

   localparam int DIV_W = RATIO_W + 1;

   if (RATIO_W < 1 || RATIO_W > 8) begin : g_bad_ratio
      $error("spi_boot_clkdiv: RATIO_W out of range");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] low_len;
   logic [DIV_W-1:0] div_new;
   logic             sck_q;

   assign div_new  = DIV_W'(ratio) + DIV_W'(2);
   assign low_len  = div_q - (div_q >> 1);
   assign rise_evt = en && (cnt_q == (low_len - 1'b1));
   assign fall_evt = en && (cnt_q == (div_q - 1'b1));
   assign sck      = sck_q;

   // The divisor is captured only while idle or at the end of a period.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= DIV_W'(2);
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else if (!en) begin
         div_q <= div_new;
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else if (fall_evt) begin
         div_q <= div_new;
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (rise_evt) sck_q <= 1'b1;
      end
   end

   // R7: divisor holds for the whole of a running period
   p_div_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !fall_evt) |=> (div_q == $past(div_q)));

endmodule

// File: rtl/spi_boot_seq.sv
module spi_boot_seq
   import spi_boot_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               supply_mode,
   input  logic [OPC_W-1:0]   opcode,
   input  logic [DUMMY_W-1:0] dummy,
   input  logic [PWRC_W-1:0]  pwr_cycles,
   input  logic               load_done,
   input  logic               rise_evt,
   input  logic               fall_evt,
   output logic               run_en,
   output logic               cs_n,
   output logic               mosi,
   output logic               sample_en,
   output logic               parked
);

   localparam int CMD_BITS = OPC_W + ADDR_W;
   localparam int CW0      = $clog2(CMD_BITS);
   localparam int CNT_W    = (CW0 > DUMMY_W) ? CW0 : DUMMY_W;

   if (CMD_BITS < 8 || CNT_W < 3) begin : g_bad_cmd
      $error("spi_boot_seq: command too short");
   end

   fetch_st_t           st_q;
   logic [PWRC_W-1:0]   pcnt_q;
   logic [CMD_BITS-1:0] cmd_q;
   logic [CNT_W-1:0]    bit_q;
   logic [DUMMY_W-1:0]  dummy_q;
   logic                done_req_q;
   logic                cs_q;

   assign run_en    = (st_q == ST_CMD) || (st_q == ST_DUMMY) || (st_q == ST_DATA);
   assign cs_n      = cs_q;
   assign mosi      = (st_q == ST_CMD) ? cmd_q[CMD_BITS-1] : 1'b0;
   assign sample_en = (st_q == ST_DATA) && rise_evt;
   assign parked    = (st_q == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_PWR;
         pcnt_q     <= '0;
         cmd_q      <= '0;
         bit_q      <= '0;
         dummy_q    <= '0;
         done_req_q <= 1'b0;
         cs_q       <= 1'b1;
      end else begin
         if (load_done) done_req_q <= 1'b1;
         case (st_q)
            ST_PWR: begin
               if (!supply_mode || (pcnt_q >= pwr_cycles)) begin
                  st_q    <= ST_CMD;
                  cs_q    <= 1'b0;
                  cmd_q   <= {opcode, {ADDR_W{1'b0}}};
                  dummy_q <= dummy;
                  bit_q   <= '0;
               end else begin
                  pcnt_q <= pcnt_q + 1'b1;
               end
            end
            ST_CMD: if (fall_evt) begin
               cmd_q <= cmd_q << 1;
               if (bit_q == CNT_W'(CMD_BITS - 1)) begin
                  bit_q <= '0;
                  st_q  <= (dummy_q == '0) ? ST_DATA : ST_DUMMY;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
            ST_DUMMY: if (fall_evt) begin
               if ((bit_q + 1'b1) == CNT_W'(dummy_q)) begin
                  bit_q <= '0;
                  st_q  <= ST_DATA;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
            ST_DATA: if (fall_evt) begin
               bit_q <= bit_q + 1'b1;
               if (done_req_q && (bit_q[2:0] == 3'd7)) begin
                  st_q <= ST_DONE;
                  cs_q <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/spi_boot_pack.sv
module spi_boot_pack #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_en,
   input  logic              bit_in,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data
);

   localparam int NB     = WORD_W / 8;
   localparam int LANE_W = (NB > 1) ? $clog2(NB) : 1;

   if ((WORD_W % 8) != 0 || WORD_W < 16) begin : g_bad_word
      $error("spi_boot_pack: WORD_W must be a multiple of 8, at least 16");
   end

   logic [2:0]        bit_q;
   logic [LANE_W-1:0] lane_q;
   logic [6:0]        part_q;
   logic [WORD_W-1:0] acc_q;
   logic [WORD_W-1:0] word_next;
   logic [7:0]        byte_w;
   logic              valid_q;
   logic [WORD_W-1:0] data_q;

   assign byte_w = {part_q, bit_in};

   // Completed byte lands in the lane selected by the byte index, low lane first.
   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign word_next[8*i +: 8] = (lane_q == LANE_W'(i)) ? byte_w : acc_q[8*i +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q   <= '0;
         lane_q  <= '0;
         part_q  <= '0;
         acc_q   <= '0;
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= 1'b0;
         if (sample_en) begin
            part_q <= {part_q[5:0], bit_in};
            bit_q  <= bit_q + 1'b1;
            if (bit_q == 3'd7) begin
               acc_q <= word_next;
               if (lane_q == LANE_W'(NB - 1)) begin
                  lane_q  <= '0;
                  valid_q <= 1'b1;
                  data_q  <= word_next;
               end else begin
                  lane_q <= lane_q + 1'b1;
               end
            end
         end
      end
   end

   assign word_valid = valid_q;
   assign word_data  = data_q;

   // R6: a word strobe never lasts more than one cycle
   p_word_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

endmodule

// File: rtl/spi_boot_fetch.sv
module spi_boot_fetch
   import spi_boot_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int WORD_W      = 32,
   parameter int SUPPLY_PINS = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   supply_mode,
   input  logic                   reg_wr,
   input  logic [CTRL_W-1:0]      reg_wdata,
   output logic                   flash_cs_n,
   output logic                   flash_sck,
   output logic                   flash_mosi,
   input  logic                   flash_miso,
   output logic [SUPPLY_PINS-1:0] flash_pwr,
   output logic                   word_valid,
   output logic [WORD_W-1:0]      word_data,
   input  logic                   load_done
);

   if (SUPPLY_PINS < 1) begin : g_bad_pins
      $error("spi_boot_fetch: SUPPLY_PINS must be at least 1");
   end

   ctrl_t ctrl_q;
   logic  run_en, rise_evt, fall_evt, sample_en, parked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl_q <= ctrl_t'(CTRL_RESET);
      else if (reg_wr) ctrl_q <= ctrl_t'(reg_wdata);
   end

   spi_boot_clkdiv #(.RATIO_W(RATIO_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (run_en),
      .ratio    (ctrl_q.ratio),
      .sck      (flash_sck),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   spi_boot_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_mode (supply_mode),
      .opcode      (ctrl_q.opcode),
      .dummy       (ctrl_q.dummy),
      .pwr_cycles  (ctrl_q.pwr_cycles),
      .load_done   (load_done),
      .rise_evt    (rise_evt),
      .fall_evt    (fall_evt),
      .run_en      (run_en),
      .cs_n        (flash_cs_n),
      .mosi        (flash_mosi),
      .sample_en   (sample_en),
      .parked      (parked)
   );

   spi_boot_pack #(.WORD_W(WORD_W)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_en  (sample_en),
      .bit_in     (flash_miso),
      .word_valid (word_valid),
      .word_data  (word_data)
   );

   for (genvar i = 0; i < SUPPLY_PINS; i++) begin : g_pwr
      assign flash_pwr[i] = supply_mode & ~parked;
   end

   // R2: serial clock idles low whenever the flash is deselected
   p_idle_sck_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flash_cs_n |-> !flash_sck);

   // R4: MOSI only moves while the serial clock is low
   p_mosi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flash_sck && $past(flash_sck)) |-> $stable(flash_mosi));

   // R8: supply pins high during an access in supply-control mode
   p_pwr_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_mode && !flash_cs_n) |-> (&flash_pwr));

   // R10: pins parked when the download ends
   p_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flash_cs_n) |-> (!flash_sck && !flash_mosi && (flash_pwr == '0)));

endmodule

// File: tb/test_spi_boot_fetch.sv
`timescale 1ns/1ps
module test_spi_boot_fetch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        supply_mode = 1'b1;
   logic        reg_wr = 1'b0;
   logic [30:0] reg_wdata = '0;
   logic        flash_cs_n, flash_sck, flash_mosi;
   logic        flash_miso = 1'b0;
   logic [2:0]  flash_pwr;
   logic        word_valid;
   logic [31:0] word_data;
   logic        load_done = 1'b0;

   always #2 clk = ~clk;

   spi_boot_fetch i_spi_boot_fetch (
      .clk(clk), .rst_n(rst_n), .supply_mode(supply_mode),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .flash_cs_n(flash_cs_n), .flash_sck(flash_sck), .flash_mosi(flash_mosi),
      .flash_miso(flash_miso), .flash_pwr(flash_pwr),
      .word_valid(word_valid), .word_data(word_data), .load_done(load_done)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   localparam int LIMIT = 150000;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [30:0] ctrl_word(input int p, input int dm, input int op, input int ratio);
      return 31'((p << 15) | (dm << 12) | (op << 4) | ratio);
   endfunction

   // session configuration, written by the stimulus only
   int        sess_id = 0;
   int        s_dummy, la, ha, lb, hb;
   bit        chg;
   bit        mon_on = 0;
   logic [7:0] data [32];

   // monitor state, written by the monitor only
   int        seen_id = 0;
   int        rises, run, last_low, last_high, wcnt, idx;
   int        bad_period, bad_pwr, bad_l, bad_h;
   logic [31:0] cmd_bits, exp_w;
   bit        prev_sck;

   always @(negedge clk) begin
      if (seen_id != sess_id) begin
         seen_id = sess_id; rises = 0; run = 0; last_low = 0; last_high = 0;
         wcnt = 0; bad_period = 0; bad_pwr = 0; bad_l = 0; bad_h = 0;
         cmd_bits = '0; prev_sck = 1'b0; flash_miso = 1'b0;
      end
      if (mon_on && rst_n) begin
         if (!flash_cs_n) begin
            if (supply_mode ? (flash_pwr != 3'b111) : (flash_pwr != 3'b000)) bad_pwr++;
            if (flash_sck != prev_sck) begin
               if (flash_sck) begin
                  last_low = run;
                  if (rises < 32) cmd_bits = {cmd_bits[30:0], flash_mosi};
                  rises++;
               end else begin
                  last_high = run;
                  if (!((last_low == la && last_high == ha) ||
                        (chg && last_low == lb && last_high == hb))) begin
                     bad_period++; bad_l = last_low; bad_h = last_high;
                  end
               end
               run = 1;
            end else begin
               run++;
            end
            prev_sck = flash_sck;
            if (!flash_sck) begin
               idx = rises - 32 - s_dummy;
               if (idx >= 0 && idx < 256) flash_miso = data[idx/8][7 - (idx % 8)];
               else flash_miso = 1'b0;
            end
         end
         if (word_valid) begin
            exp_w = {data[4*wcnt+3], data[4*wcnt+2], data[4*wcnt+1], data[4*wcnt]};
            chk(word_data == exp_w, "R6/R5 word assembly", word_data, exp_w);
            wcnt++;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > LIMIT) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, LIMIT);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic run_session(input bit sup, input bit do_wr, input logic [30:0] wval,
                              input int p, input int d, input int dm, input int op,
                              input bit do_chg, input logic [30:0] cval, input int d2);
      int n, db, wc;
      supply_mode = sup;
      rst_n = 1'b0;
      reg_wr = 1'b0;
      load_done = 1'b0;
      for (int i = 0; i < 32; i++) data[i] = 8'($urandom);
      la = d - d/2; ha = d/2; lb = d2 - d2/2; hb = d2/2; chg = 1'b0; s_dummy = dm;
      sess_id++;
      mon_on = 1'b1;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(flash_cs_n == 1'b1, "R1 cs_n in reset", flash_cs_n, 1);
      chk({flash_sck, flash_mosi, word_valid} == 3'b000, "R1 sck/mosi/valid in reset",
          {flash_sck, flash_mosi, word_valid}, 0);
      rst_n = 1'b1;
      if (do_wr) begin reg_wr = 1'b1; reg_wdata = wval; end
      n = 0;
      while (cyc < LIMIT) begin
         @(posedge clk); n++;
         @(negedge clk); reg_wr = 1'b0;
         if (!flash_cs_n) break;
      end
      chk(n == p + 1, sup ? "R8 R3 power-up delay" : "R9 immediate start", n, p + 1);
      while (rises < 32 && cyc < LIMIT) @(negedge clk);
      chk(cmd_bits == {8'(op), 24'h0}, "R4 R11 command bits", cmd_bits, {8'(op), 24'h0});
      while (wcnt < 1 && cyc < LIMIT) @(negedge clk);
      if (do_chg) begin
         chg = 1'b1; reg_wr = 1'b1; reg_wdata = cval;
         @(negedge clk); reg_wr = 1'b0;
      end
      while (wcnt < 3 && cyc < LIMIT) @(negedge clk);
      load_done = 1'b1;
      @(negedge clk); load_done = 1'b0;
      while (!flash_cs_n && cyc < LIMIT) @(negedge clk);
      db = rises - 32 - dm;
      chk(db == 96 || db == 104, "R10 stop at byte boundary", db, 96);
      chk({flash_sck, flash_mosi, flash_pwr} == 5'b0, "R10 parked pins",
          {flash_sck, flash_mosi, flash_pwr}, 0);
      wc = wcnt;
      repeat (50) @(negedge clk);
      chk(wcnt == wc && flash_cs_n && !flash_sck, "R10 stays parked", wcnt, wc);
      chk(wcnt >= 3, "R6 words received", wcnt, 3);
      chk(bad_period == 0, "R2 serial clock phases", {bad_l, bad_h}, {la, ha});
      if (do_chg)
         chk(last_low == lb && last_high == hb, "R7 new divisor in force",
             {last_low, last_high}, {lb, hb});
      chk(bad_pwr == 0, sup ? "R8 supply pins high" : "R9 supply pins low", bad_pwr, 0);
      mon_on = 1'b0;
   endtask

   initial begin
      int seed_v, r_ratio, r_dm, r_op, r_p;
      seed_v = $urandom(7531);
      // defaults from reset: ratio 15, opcode 0x03, no dummy, delay 1000
      run_session(1'b1, 1'b0, '0, 1000, 17, 0, 8'h03, 1'b0, '0, 17);
      // no supply control: immediate start, supply pins low
      run_session(1'b0, 1'b0, '0, 0, 17, 0, 8'h03, 1'b0, '0, 17);
      // fastest clock, 7 dummy clocks, new opcode, delay rewritten live
      run_session(1'b1, 1'b1, ctrl_word(20, 7, 8'h0B, 0), 20, 2, 7, 8'h0B, 1'b0, '0, 2);
      // odd divisor, then a ratio change mid-download (R7)
      run_session(1'b1, 1'b1, ctrl_word(5, 3, 8'h3B, 3), 5, 5, 3, 8'h3B,
                  1'b1, ctrl_word(5, 3, 8'h3B, 2), 4);
      // constrained random settings
      for (int k = 0; k < 3; k++) begin
         r_ratio = int'($urandom_range(0, 15));
         r_dm    = int'($urandom_range(0, 7));
         r_op    = int'($urandom_range(0, 255));
         r_p     = int'($urandom_range(1, 40));
         run_session(1'b1, 1'b1, ctrl_word(r_p, r_dm, r_op, r_ratio), r_p, r_ratio + 2,
                     r_dm, r_op, 1'b0, '0, r_ratio + 2);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule